// File: doc/BRIEF.md
# Capture/Compare Channel Array

This block holds a bank of sixteen 16-bit capture/compare channels that sit beside two free-running time bases kept outside the block. Software sets each channel to watch either time base, and to act either as a capture channel (its pin is an input) or as a compare channel (its pin is an output). A capture channel stores the value of its time base when the chosen edge appears on its pin. A compare channel watches for its time base reaching the stored value, then raises an interrupt and/or moves its pin, as its mode selects.

Compare behaviour comes in five flavours: interrupt on every match, pin toggle on every match, interrupt once per timer period, a set-on-match / clear-on-overflow pulse that fires once per period, and a paired mode in which a channel in the lower half and its partner eight places up both toggle the lower channel's pin. The overflow pulse of each time base marks the end of a period.

Top module: `capcmp_array`

## Requirements
- R1: Registers sit at addresses 0..15 (channel value) and 16..31 (channel configuration, bits [2:0] mode, bit 3 timer select with 0 = timer A and 1 = timer B, bits [5:4] capture trigger). Configuration reads return those six bits with the upper bits zero. After reset every register reads 0, every pin output is 0 and no interrupt is raised.
- R2: Mode codes: 0 off, 1 capture, 2 compare-interrupt, 3 compare-toggle, 4 compare-interrupt-once, 5 compare-pulse, 6 paired toggle, 7 treated as off. In capture mode the pin passes a two-flop synchronizer; the trigger field selects 01 rising, 10 falling, 11 both, 00 none. A selected edge loads the assigned timer into the value register and gives a one-cycle interrupt; unselected edges change nothing.
- R3: A pin level change first sampled at clock edge k is captured at edge k+2; a register write in that same cycle loses, and the captured timer value is kept.
- R4: A compare match event occurs in the first cycle in which the channel value equals its assigned timer; holding equality raises no further event. Each taken event gives a one-cycle interrupt in the following cycle.
- R5: In mode 2 every event raises the interrupt, several per period are possible, and the pin is untouched.
- R6: In mode 3 every event toggles the channel's pin and raises the interrupt.
- R7: In mode 4 only the first event after the assigned timer's overflow pulse is taken; later events raise nothing until the next overflow of that timer.
- R8: In mode 5 a taken event sets the pin to 1 and the assigned timer's overflow clears it to 0; after one event further matches are ignored until that overflow, and a match in the overflow cycle itself is taken.
- R9: In mode 6, channel c (c < 8) and channel c+8 each toggle the pin of channel c on their own events and each raise their own interrupt; channel c+8's own pin is unchanged.
- R10: Compare and overflow handling use only the assigned timer: matches and overflows of the other timer have no effect.
- R11: A channel in mode 0 or 7 raises no interrupt and leaves its pin unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Read data, combinational |
| tmr_a | input | 16 | Time base A count |
| tmr_b | input | 16 | Time base B count |
| ovf_a | input | 1 | Time base A overflow pulse |
| ovf_b | input | 1 | Time base B overflow pulse |
| pin_in | input | 16 | Channel pin inputs |
| pin_out | output | 16 | Channel pin outputs |
| irq | output | 16 | Per-channel interrupt pulses |

## Verification
The compare path is driven by stepping a timer onto a channel value, holding it there, stepping away and returning, which separates entry-only events from level matching and shows whether repeat matches inside one period are taken or locked out. Overflow pulses on the assigned and on the other timer, alone and coinciding with a match, distinguish correct lockout release from release by the wrong time base. Capture is tried with rising and falling pin transitions on channels set for each trigger code, so a mis-decoded trigger or wrong timer shows as a wrong pulse count or stored value, and a write placed exactly on the capture edge exposes the precedence order.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

   localparam int CFG_W = 6;

   typedef enum logic [2:0] {
      M_OFF  = 3'd0,
      M_CAP  = 3'd1,
      M_CMP0 = 3'd2,
      M_CMP1 = 3'd3,
      M_CMP2 = 3'd4,
      M_CMP3 = 3'd5,
      M_DBL  = 3'd6,
      M_RSV  = 3'd7
   } ch_mode_e;

   typedef struct packed {
      logic [1:0] trig;
      logic       tsel;
      ch_mode_e   mode;
   } ch_cfg_t;

endpackage

// File: rtl/capcmp_sync.sv
module capcmp_sync #(
   parameter int NCH    = 16,
   parameter int STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] pin_in,
   output logic [NCH-1:0] rise,
   output logic [NCH-1:0] fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("capcmp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][NCH-1:0] chain_q;
   logic [NCH-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= pin_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign rise = chain_q[STAGES-1] & ~prev_q;
   assign fall = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/capcmp_chan.sv
module capcmp_chan
   import capcmp_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_val,
   input  logic          wr_cfg,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] tmr_a,
   input  logic [DW-1:0] tmr_b,
   input  logic          ovf_a,
   input  logic          ovf_b,
   input  logic          rise,
   input  logic          fall,
   output logic [DW-1:0] val_o,
   output ch_cfg_t       cfg_o,
   output logic          evt_o,
   output logic          ovf_o,
   output logic          cap_o,
   output logic          lock_o,
   output logic          irq_o
);

   logic [DW-1:0] val_q;
   ch_cfg_t       cfg_q;
   logic          eq_q;
   logic          lock_q;
   logic          irq_q;

   logic [DW-1:0] tmr_sel;
   logic          ovf_sel;
   logic          is_cmp;
   logic          one_shot;
   logic          eq;
   logic          hit;
   logic          evt;
   logic          cap;

   assign tmr_sel  = cfg_q.tsel ? tmr_b : tmr_a;
   assign ovf_sel  = cfg_q.tsel ? ovf_b : ovf_a;
   assign is_cmp   = cfg_q.mode inside {M_CMP0, M_CMP1, M_CMP2, M_CMP3, M_DBL};
   assign one_shot = cfg_q.mode inside {M_CMP2, M_CMP3};
   assign eq       = (val_q == tmr_sel);
   assign hit      = is_cmp && eq && !eq_q;
   // a period boundary in this very cycle reopens the channel
   assign evt      = hit && !(one_shot && lock_q && !ovf_sel);
   assign cap      = (cfg_q.mode == M_CAP) &&
                     ((cfg_q.trig[0] && rise) || (cfg_q.trig[1] && fall));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q  <= '0;
         cfg_q  <= '0;
         eq_q   <= 1'b0;
         lock_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (cap)         val_q <= tmr_sel;
         else if (wr_val) val_q <= wdata;
         if (wr_cfg)      cfg_q <= ch_cfg_t'(wdata[CFG_W-1:0]);
         eq_q <= eq;
         if (!one_shot)    lock_q <= 1'b0;
         else if (evt)     lock_q <= 1'b1;
         else if (ovf_sel) lock_q <= 1'b0;
         irq_q <= evt || cap;
      end
   end

   assign val_o  = val_q;
   assign cfg_o  = cfg_q;
   assign evt_o  = evt;
   assign ovf_o  = ovf_sel;
   assign cap_o  = cap;
   assign lock_o = lock_q;
   assign irq_o  = irq_q;

endmodule

// File: rtl/capcmp_pin.sv
module capcmp_pin
   import capcmp_pkg::*;
#(
   parameter bit OWN_DBL = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  ch_mode_e mode,
   input  logic     evt,
   input  logic     ovf,
   input  logic     mate_tgl,
   output logic     pin_o
);

   logic pin_q;
   logic set_p;
   logic clr_p;
   logic tgl_p;

   assign set_p = (mode == M_CMP3) && evt;
   assign clr_p = (mode == M_CMP3) && ovf;
   assign tgl_p = ((mode == M_CMP1) && evt) ||
                  (OWN_DBL && (mode == M_DBL) && evt) ||
                  mate_tgl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pin_q <= 1'b0;
      else if (set_p) pin_q <= 1'b1;
      else if (clr_p) pin_q <= 1'b0;
      else if (tgl_p) pin_q <= !pin_q;
   end

   assign pin_o = pin_q;

endmodule

// File: rtl/capcmp_array.sv
module capcmp_array
   import capcmp_pkg::*;
#(
   parameter int NCH       = 16,
   parameter int DW        = 16,
   parameter int SYNC_STGS = 2,
   localparam int IW       = $clog2(NCH),
   localparam int AW       = IW + 1,
   localparam int HALF     = NCH / 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  logic [DW-1:0]  wr_data,
   input  logic [AW-1:0]  rd_addr,
   output logic [DW-1:0]  rd_data,
   input  logic [DW-1:0]  tmr_a,
   input  logic [DW-1:0]  tmr_b,
   input  logic           ovf_a,
   input  logic           ovf_b,
   input  logic [NCH-1:0] pin_in,
   output logic [NCH-1:0] pin_out,
   output logic [NCH-1:0] irq
);

   if (NCH < 2 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("capcmp_array: NCH must be a power of two, at least 2");
   end
   if (DW < CFG_W) begin : g_bad_dw
      $error("capcmp_array: DW too narrow for the configuration field");
   end

   logic [NCH-1:0]          rise;
   logic [NCH-1:0]          fall;
   logic [NCH-1:0]          evt_v;
   logic [NCH-1:0]          cap_v;
   logic [NCH-1:0]          lock_v;
   logic [NCH-1:0]          ovf_v;
   logic [NCH-1:0]          tsel_v;
   logic [NCH-1:0]          mate_tgl;
   logic [NCH-1:0][DW-1:0]  val_v;
   logic [NCH-1:0][2:0]     mode_v;
   ch_cfg_t                 cfg_v [NCH];

   logic [IW-1:0] wsel;
   logic [IW-1:0] rsel;
   logic          w_is_cfg;
   logic          r_is_cfg;

   assign wsel     = wr_addr[IW-1:0];
   assign w_is_cfg = wr_addr[AW-1];
   assign rsel     = rd_addr[IW-1:0];
   assign r_is_cfg = rd_addr[AW-1];

   capcmp_sync #(.NCH(NCH), .STAGES(SYNC_STGS)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_in),
      .rise   (rise),
      .fall   (fall)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit_addr;
      assign hit_addr = wr_en && (wsel == IW'(c));

      capcmp_chan #(.DW(DW)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_val (hit_addr && !w_is_cfg),
         .wr_cfg (hit_addr && w_is_cfg),
         .wdata  (wr_data),
         .tmr_a  (tmr_a),
         .tmr_b  (tmr_b),
         .ovf_a  (ovf_a),
         .ovf_b  (ovf_b),
         .rise   (rise[c]),
         .fall   (fall[c]),
         .val_o  (val_v[c]),
         .cfg_o  (cfg_v[c]),
         .evt_o  (evt_v[c]),
         .ovf_o  (ovf_v[c]),
         .cap_o  (cap_v[c]),
         .lock_o (lock_v[c]),
         .irq_o  (irq[c])
      );

      assign mode_v[c] = cfg_v[c].mode;
      assign tsel_v[c] = cfg_v[c].tsel;

      if (c < HALF) begin : g_lower
         assign mate_tgl[c] = (cfg_v[c+HALF].mode == M_DBL) && evt_v[c+HALF];
      end else begin : g_upper
         assign mate_tgl[c] = 1'b0;
      end

      capcmp_pin #(.OWN_DBL(c < HALF)) u_pin (
         .clk      (clk),
         .rst_n    (rst_n),
         .mode     (cfg_v[c].mode),
         .evt      (evt_v[c]),
         .ovf      (ovf_v[c]),
         .mate_tgl (mate_tgl[c]),
         .pin_o    (pin_out[c])
      );
   end

   always_comb begin
      if (r_is_cfg) rd_data = {{(DW-CFG_W){1'b0}}, cfg_v[rsel]};
      else          rd_data = val_v[rsel];
   end

endmodule

// File: rtl/capcmp_array_chk.sv
module capcmp_array_chk
   import capcmp_pkg::*;
#(
   parameter int NCH = 16,
   parameter int DW  = 16,
   localparam int HALF = NCH / 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [DW-1:0]          tmr_a,
   input logic [DW-1:0]          tmr_b,
   input logic [NCH-1:0]         irq,
   input logic [NCH-1:0]         pin_out,
   input logic [NCH-1:0]         evt_v,
   input logic [NCH-1:0]         cap_v,
   input logic [NCH-1:0]         lock_v,
   input logic [NCH-1:0]         ovf_v,
   input logic [NCH-1:0]         tsel_v,
   input logic [NCH-1:0][2:0]    mode_v,
   input logic [NCH-1:0][DW-1:0] val_v
);

   for (genvar c = 0; c < NCH; c++) begin : g_c
      logic mate_dbl;
      if (c < HALF) begin : g_lo
         assign mate_dbl = (mode_v[c+HALF] == M_DBL);
      end else begin : g_hi
         assign mate_dbl = 1'b0;
      end

      a_r4_event_irq: assert property (@(posedge clk) disable iff (!rst_n)
         evt_v[c] |=> irq[c]);

      a_r2_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
         cap_v[c] |=> (val_v[c] == $past(tsel_v[c] ? tmr_b : tmr_a)));

      a_r5_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_v[c] == M_CMP0 && !mate_dbl) |=> $stable(pin_out[c]));

      a_r6_pin_toggle: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_v[c] == M_CMP1 && evt_v[c] && !mate_dbl) |=> (pin_out[c] != $past(pin_out[c])));

      a_r7_lockout: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_v[c] == M_CMP2 && lock_v[c] && !ovf_v[c]) |-> !evt_v[c]);

      a_r8_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_v[c] == M_CMP3 && ovf_v[c] && !evt_v[c] && !mate_dbl) |=> !pin_out[c]);

      a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_v[c] == M_OFF || mode_v[c] == M_RSV) |=> !irq[c]);
   end

endmodule

bind capcmp_array capcmp_array_chk #(.NCH(NCH), .DW(DW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tmr_a   (tmr_a),
   .tmr_b   (tmr_b),
   .irq     (irq),
   .pin_out (pin_out),
   .evt_v   (evt_v),
   .cap_v   (cap_v),
   .lock_v  (lock_v),
   .ovf_v   (ovf_v),
   .tsel_v  (tsel_v),
   .mode_v  (mode_v),
   .val_v   (val_v)
);

// File: tb/capcmp_array_test.sv
`timescale 1ns/1ps
module capcmp_array_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [4:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic [15:0] tmr_a = '0;
   logic [15:0] tmr_b = '0;
   logic        ovf_a = 1'b0;
   logic        ovf_b = 1'b0;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out;
   logic [15:0] irq;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   capcmp_array uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .tmr_a(tmr_a), .tmr_b(tmr_b), .ovf_a(ovf_a), .ovf_b(ovf_b),
      .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   function automatic logic [15:0] cfgw(input logic [2:0] m, input logic ts, input logic [1:0] tr);
      return {10'd0, tr, ts, m};
   endfunction

   task automatic t_reset();
      logic [15:0] d;
      chk("R1 reset irq", irq, 16'h0);
      chk("R1 reset pins", pin_out, 16'h0);
      rd(5'd3, d);  chk("R1 reset value", d, 16'h0);
      rd(5'd19, d); chk("R1 reset cfg", d, 16'h0);
   endtask

   task automatic t_regs();
      logic [15:0] d;
      wr(5'd5, 16'hBEEF);
      wr(5'd21, 16'hFF2D);
      rd(5'd5, d);  chk("R1 value readback", d, 16'hBEEF);
      rd(5'd21, d); chk("R1 cfg readback six bits", d, 16'h002D);
      wr(5'd21, 16'h0000);
   endtask

   task automatic t_mode0();
      wr(5'd0, 16'd100);
      wr(5'd16, cfgw(3'd2, 1'b0, 2'b00));
      tmr_a = 16'd100; tick();
      chk("R4 R5 mode0 irq on match", irq[0], 1'b1);
      chk("R5 mode0 pin untouched", pin_out[0], 1'b0);
      tick();
      chk("R4 held equality no event", irq[0], 1'b0);
      tmr_a = 16'd101; tick();
      tmr_a = 16'd100; tick();
      chk("R5 mode0 second match same period", irq[0], 1'b1);
      tmr_a = 16'd0; tick();
   endtask

   task automatic t_mode1();
      wr(5'd1, 16'd200);
      wr(5'd17, cfgw(3'd3, 1'b0, 2'b00));
      tmr_a = 16'd200; tick();
      chk("R6 mode1 pin toggles high", pin_out[1], 1'b1);
      chk("R6 mode1 irq", irq[1], 1'b1);
      tmr_a = 16'd0; tick();
      tmr_a = 16'd200; tick();
      chk("R6 mode1 pin toggles low", pin_out[1], 1'b0);
      tmr_a = 16'd0; tick();
   endtask

   task automatic t_mode2();
      wr(5'd2, 16'd300);
      wr(5'd18, cfgw(3'd4, 1'b0, 2'b00));
      tmr_a = 16'd300; tick();
      chk("R7 mode2 first irq", irq[2], 1'b1);
      tmr_a = 16'd0; tick();
      tmr_a = 16'd300; tick();
      chk("R7 mode2 repeat ignored", irq[2], 1'b0);
      tmr_a = 16'd0; ovf_a = 1'b1; tick();
      ovf_a = 1'b0; tick();
      tmr_a = 16'd300; tick();
      chk("R7 mode2 after overflow", irq[2], 1'b1);
      tmr_a = 16'd0; tick();
   endtask

   task automatic t_mode3();
      wr(5'd3, 16'd400);
      wr(5'd19, cfgw(3'd5, 1'b0, 2'b00));
      tmr_a = 16'd400; tick();
      chk("R8 mode3 pin set", pin_out[3], 1'b1);
      chk("R8 mode3 irq", irq[3], 1'b1);
      tmr_a = 16'd0; tick();
      tmr_a = 16'd400; tick();
      chk("R8 mode3 repeat ignored", irq[3], 1'b0);
      tmr_a = 16'd0; ovf_a = 1'b1; tick();
      ovf_a = 1'b0;
      chk("R8 mode3 overflow clears pin", pin_out[3], 1'b0);
      tmr_a = 16'd400; tick();
      chk("R8 mode3 pin set again", pin_out[3], 1'b1);
      tmr_a = 16'd0; tick();
      tmr_a = 16'd400; ovf_a = 1'b1; tick();
      ovf_a = 1'b0;
      chk("R8 match in overflow cycle taken", irq[3], 1'b1);
      chk("R8 pin high after overflow-cycle match", pin_out[3], 1'b1);
      tmr_a = 16'd0; tick();
   endtask

   task automatic t_tsel();
      wr(5'd4, 16'd500);
      wr(5'd20, cfgw(3'd2, 1'b1, 2'b00));
      tmr_a = 16'd500; tick();
      chk("R10 other timer no match", irq[4], 1'b0);
      tmr_a = 16'd0; tmr_b = 16'd500; tick();
      chk("R10 assigned timer match", irq[4], 1'b1);
      tmr_b = 16'd0; tick();
      wr(5'd6, 16'd600);
      wr(5'd22, cfgw(3'd4, 1'b1, 2'b00));
      tmr_b = 16'd600; tick();
      chk("R10 once-mode first on timer B", irq[6], 1'b1);
      tmr_b = 16'd0; ovf_a = 1'b1; tick();
      ovf_a = 1'b0; tmr_b = 16'd600; tick();
      chk("R10 other overflow keeps lockout", irq[6], 1'b0);
      tmr_b = 16'd0; ovf_b = 1'b1; tick();
      ovf_b = 1'b0; tmr_b = 16'd600; tick();
      chk("R10 own overflow releases", irq[6], 1'b1);
      tmr_b = 16'd0; tick();
   endtask

   task automatic t_double();
      wr(5'd7, 16'd700);
      wr(5'd15, 16'd710);
      wr(5'd23, cfgw(3'd6, 1'b0, 2'b00));
      wr(5'd31, cfgw(3'd6, 1'b0, 2'b00));
      tmr_a = 16'd700; tick();
      chk("R9 lower match toggles pin", pin_out[7], 1'b1);
      chk("R9 lower irq", irq[7], 1'b1);
      tmr_a = 16'd710; tick();
      chk("R9 upper match toggles lower pin", pin_out[7], 1'b0);
      chk("R9 upper irq", irq[15], 1'b1);
      chk("R9 upper own pin unchanged", pin_out[15], 1'b0);
      tmr_a = 16'd0; tick();
   endtask

   task automatic t_idle();
      wr(5'd8, 16'd800);
      wr(5'd9, 16'd800);
      wr(5'd25, cfgw(3'd7, 1'b0, 2'b00));
      tmr_a = 16'd800; tick();
      chk("R11 off channel no irq", irq[8], 1'b0);
      chk("R11 reserved mode no irq", irq[9], 1'b0);
      chk("R11 idle pins held", {pin_out[9], pin_out[8]}, 2'b00);
      tmr_a = 16'd0; tick();
   endtask

   task automatic t_capture();
      logic [15:0] d;
      int c10, c11, c12, c14;
      wr(5'd26, cfgw(3'd1, 1'b0, 2'b01));
      wr(5'd27, cfgw(3'd1, 1'b0, 2'b11));
      wr(5'd28, cfgw(3'd1, 1'b0, 2'b00));
      wr(5'd30, cfgw(3'd1, 1'b0, 2'b10));
      tmr_a = 16'd1234;
      c10 = 0; c11 = 0; c12 = 0; c14 = 0;
      pin_in = 16'h5C00;
      for (int i = 0; i < 5; i++) begin
         tick();
         c10 += irq[10]; c11 += irq[11]; c12 += irq[12]; c14 += irq[14];
      end
      chk("R2 rising trigger captures", c10, 1);
      chk("R2 both trigger on rise", c11, 1);
      chk("R2 no trigger ignores rise", c12, 0);
      chk("R2 falling trigger ignores rise", c14, 0);
      tmr_a = 16'd777;
      c10 = 0; c11 = 0; c12 = 0; c14 = 0;
      pin_in = 16'h0000;
      for (int i = 0; i < 5; i++) begin
         tick();
         c10 += irq[10]; c11 += irq[11]; c12 += irq[12]; c14 += irq[14];
      end
      chk("R2 rising trigger ignores fall", c10, 0);
      chk("R2 both trigger on fall", c11, 1);
      chk("R2 falling trigger captures", c14, 1);
      rd(5'd10, d); chk("R2 value from rise kept", d, 16'd1234);
      rd(5'd11, d); chk("R2 value from fall", d, 16'd777);
      rd(5'd12, d); chk("R2 untriggered value unchanged", d, 16'd0);
      rd(5'd14, d); chk("R2 falling captured value", d, 16'd777);
      tmr_a = 16'd0;
   endtask

   task automatic t_cap_prec();
      logic [15:0] d;
      wr(5'd29, cfgw(3'd1, 1'b1, 2'b01));
      tmr_b = 16'd4321;
      tick();
      pin_in[13] = 1'b1;
      tick();
      tick();
      wr_en = 1'b1; wr_addr = 5'd13; wr_data = 16'h5555;
      tick();
      wr_en = 1'b0;
      chk("R3 capture irq at third edge", irq[13], 1'b1);
      rd(5'd13, d); chk("R3 capture beats write", d, 16'd4321);
      tmr_b = 16'd0;
      tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_regs();
      t_mode0();
      t_mode1();
      t_mode2();
      t_mode3();
      t_tsel();
      t_double();
      t_idle();
      t_capture();
      t_cap_prec();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule